// File: doc/BRIEF.md
# Asynchronous SRAM Chip-Select Strobe Timer

This block drives the control pins of one chip-select area on an asynchronous SRAM bus. It accepts a single access at a time from the core and plays it out on the bus as three phases. In the setup phase address and chip select are driven but no strobe is active. In the strobe phase the read strobe or the byte-lane enables are active. In the hold phase the strobe is negated while address and chip select stay put. The block's clock `clk` runs at twice the bus cycle rate, so one `clk` period is one half bus cycle, and every pin edge falls on a half-cycle boundary.

A 32-bit configuration word sets the phase lengths and the byte-lane signalling style. The setup and hold codes each add an odd number of half cycles. A width code sets the strobe length in whole bus cycles. The lane-mode bit chooses which of two pins, the per-lane enables or the read/write direction line, carries the write pulse. The other pin then spans the whole access. The core holds a request until a one-cycle acknowledge comes back; read data is latched on the edge that ends the strobe.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: While `rst_n` is low, and whenever no access is in progress, `bus_cs_n`, `bus_rd_n`, every bit of `bus_we_n` and `bus_rdwr` are high, `bus_wdata_oe` and `ack` are low, and after reset `cfg_rdata` reads 0.
- R2: The configuration word holds the hold code in bits 1:0, the strobe-width code in bits 5:2, the setup code in bits 12:11 and the lane-mode bit in bit 20. All other bits read 0 and ignore writes, so writing all ones reads back 32'h0010_183F.
- R3: From the clock edge that pulls `bus_cs_n` low to the edge that starts the strobe there are 2*setup+1 `clk` cycles (0.5, 1.5, 2.5 or 3.5 bus cycles for codes 0 to 3).
- R4: The strobe phase lasts 2*width `clk` cycles, with a width code of 0 treated as 1.
- R5: From the edge that ends the strobe to the edge that raises `bus_cs_n` there are 2*hold+1 `clk` cycles, so `bus_cs_n` stays low for exactly (2*setup+1)+(2*max(width,1))+(2*hold+1) cycles.
- R6: With lane mode 0, `bus_we_n[i]` is low only during the strobe phase and only when byte enable i of the request was 1, for reads and writes alike; `bus_rdwr` is low (write) for the whole time `bus_cs_n` is low on a write and stays high on a read.
- R7: With lane mode 1, `bus_we_n[i]` is low for the whole time `bus_cs_n` is low when byte enable i was 1, for reads and writes alike; `bus_rdwr` is low only during the strobe phase of a write.
- R8: `bus_rd_n` is low exactly during the strobe phase of a read and never during a write.
- R9: `ack` is high for one `clk` cycle, the cycle in which `bus_cs_n` has just returned high; `rd_data` takes the value of `bus_rdata` present at the edge that ends a read's strobe and holds it until the next read.
- R10: No access is accepted while `ack` is high, so `bus_cs_n` stays high for at least two `clk` cycles (one bus cycle) between accesses even if `req_valid` never drops.
- R11: Timing codes and lane mode are taken when a request is accepted; a configuration write during an access affects only later accesses.
- R12: `bus_addr` holds the accepted address without change while `bus_cs_n` is low; on writes `bus_wdata_oe` is high and `bus_wdata` carries the write data for that whole time, and on reads `bus_wdata_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bus cycle rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write value |
| cfg_rdata | output | 32 | Configuration read-back |
| req_valid | input | 1 | Access request, held until `ack` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Access address |
| req_be | input | DATA_W/8 | Byte-lane enables |
| req_wdata | input | DATA_W | Write data |
| ack | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Latched read data |
| bus_addr | output | ADDR_W | Bus address |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_we_n | output | DATA_W/8 | Per-lane enables, active low |
| bus_rdwr | output | 1 | Direction, high = read, low = write |
| bus_wdata | output | DATA_W | Write data toward the SRAM |
| bus_wdata_oe | output | 1 | Write data drive enable |
| bus_rdata | input | DATA_W | Read data from the SRAM |

## Verification
A request driven before edge E is accepted at E, so `bus_cs_n` and the address change after E. The strobe starts 2*setup+1 edges later and ends 2*max(width,1) edges after that. `bus_cs_n` rises and `ack` pulses 2*hold+1 edges after the strobe ends, and `rd_data` changes on the strobe-ending edge. A configuration write is visible on `cfg_rdata` one edge later. The reference model advances one step per rising edge using the inputs held at that edge. Every output is compared against it at the following falling edge. The measured chip-select span and the gap between back-to-back accesses are therefore counted in whole `clk` periods with no half-period ambiguity.

// File: rtl/sram_strobe_pkg.sv
package sram_strobe_pkg;

    localparam int SETUP_W   = 2;
    localparam int HOLD_W    = 2;
    localparam int WIDTH_W   = 4;

    localparam int HOLD_LSB  = 0;
    localparam int WIDTH_LSB = 2;
    localparam int SETUP_LSB = 11;
    localparam int MODE_BIT  = 20;
    localparam int CFG_W     = 32;

    localparam int TICK_SPAN = (2 ** (WIDTH_W + 1)) + (2 ** (SETUP_W + 1)) + (2 ** (HOLD_W + 1));
    localparam int CNT_W     = $clog2(TICK_SPAN);

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_STROBE = 2'd2,
        PH_HOLD   = 2'd3
    } phase_e;

    typedef struct packed {
        logic [SETUP_W-1:0] setup_code;
        logic [WIDTH_W-1:0] width_code;
        logic [HOLD_W-1:0]  hold_code;
        logic               lane_mode;
    } timing_t;

endpackage

// File: rtl/sram_timing_regs.sv
module sram_timing_regs
    import sram_strobe_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output timing_t          timing,
    output logic [CFG_W-1:0] rd_data
);

    timing_t tim_d, tim_q;

    // Only the defined fields are stored; every other bit is dropped here.
    always_comb begin
        tim_d = tim_q;
        if (wr_en) begin
            tim_d.setup_code = wr_data[SETUP_LSB +: SETUP_W];
            tim_d.width_code = wr_data[WIDTH_LSB +: WIDTH_W];
            tim_d.hold_code  = wr_data[HOLD_LSB +: HOLD_W];
            tim_d.lane_mode  = wr_data[MODE_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tim_q <= '0;
        end else begin
            tim_q <= tim_d;
        end
    end

    always_comb begin
        rd_data                        = '0;
        rd_data[SETUP_LSB +: SETUP_W]  = tim_q.setup_code;
        rd_data[WIDTH_LSB +: WIDTH_W]  = tim_q.width_code;
        rd_data[HOLD_LSB +: HOLD_W]    = tim_q.hold_code;
        rd_data[MODE_BIT]              = tim_q.lane_mode;
    end

    assign timing = tim_q;

endmodule

// File: rtl/sram_phase_seq.sv
module sram_phase_seq
    import sram_strobe_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    req_valid,
    input  timing_t cfg,
    output phase_e  phase_next,
    output logic    lane_mode_next,
    output logic    accept,
    output logic    capture,
    output logic    ack
);

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
        timing_t          tim;
        logic             ack;
    } seq_t;

    seq_t s_d, s_q;
    logic [WIDTH_W-1:0] eff_width;

    // cnt holds the number of further cycles the current phase lasts.
    always_comb begin
        s_d       = s_q;
        s_d.ack   = 1'b0;
        accept    = 1'b0;
        capture   = 1'b0;
        eff_width = (s_q.tim.width_code == '0) ? WIDTH_W'(1) : s_q.tim.width_code;
        unique case (s_q.phase)
            PH_IDLE: begin
                if (req_valid && !s_q.ack) begin
                    accept    = 1'b1;
                    s_d.tim   = cfg;
                    s_d.phase = PH_SETUP;
                    s_d.cnt   = CNT_W'({cfg.setup_code, 1'b0});
                end
            end
            PH_SETUP: begin
                if (s_q.cnt == '0) begin
                    s_d.phase = PH_STROBE;
                    s_d.cnt   = CNT_W'({eff_width, 1'b0}) - CNT_W'(1);
                end else begin
                    s_d.cnt = s_q.cnt - CNT_W'(1);
                end
            end
            PH_STROBE: begin
                if (s_q.cnt == '0) begin
                    s_d.phase = PH_HOLD;
                    s_d.cnt   = CNT_W'({s_q.tim.hold_code, 1'b0});
                    capture   = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt - CNT_W'(1);
                end
            end
            PH_HOLD: begin
                if (s_q.cnt == '0) begin
                    s_d.phase = PH_IDLE;
                    s_d.ack   = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt - CNT_W'(1);
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.phase <= PH_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign phase_next     = s_d.phase;
    assign lane_mode_next = s_d.tim.lane_mode;
    assign ack            = s_q.ack;

endmodule

// File: rtl/sram_strobe_gen.sv
module sram_strobe_gen
    import sram_strobe_pkg::*;
#(
    parameter  int ADDR_W = 24,
    parameter  int DATA_W = 32,
    localparam int LANES  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  phase_e            phase_next,
    input  logic              lane_mode_next,
    input  logic              capture,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LANES-1:0]  req_be,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_cs_n,
    output logic              bus_rd_n,
    output logic [LANES-1:0]  bus_we_n,
    output logic              bus_rdwr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_wdata_oe,
    output logic [DATA_W-1:0] rd_data
);

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [LANES-1:0]  be;
        logic [DATA_W-1:0] wdata;
        logic              cs_n;
        logic              rd_n;
        logic [LANES-1:0]  we_n;
        logic              rdwr;
        logic              oe;
        logic [DATA_W-1:0] rdata;
    } pins_t;

    pins_t p_d, p_q;

    logic             wr_next;
    logic [LANES-1:0] be_next;
    logic             span_on;
    logic             pulse_on;
    logic [LANES-1:0] lane_low;

    assign wr_next  = accept ? req_write : p_q.wr;
    assign be_next  = accept ? req_be : p_q.be;
    assign span_on  = (phase_next != PH_IDLE);
    assign pulse_on = (phase_next == PH_STROBE);

    // Each lane enable follows either the whole access or only the strobe.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_low[g] = be_next[g] & (lane_mode_next ? span_on : pulse_on);
    end

    always_comb begin
        p_d       = p_q;
        if (accept) begin
            p_d.wr    = req_write;
            p_d.addr  = req_addr;
            p_d.be    = req_be;
            p_d.wdata = req_wdata;
        end
        p_d.cs_n  = !span_on;
        p_d.rd_n  = !(pulse_on && !wr_next);
        p_d.we_n  = ~lane_low;
        p_d.rdwr  = !(wr_next && (lane_mode_next ? pulse_on : span_on));
        p_d.oe    = span_on && wr_next;
        if (capture && !p_q.wr) begin
            p_d.rdata = bus_rdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q      <= '0;
            p_q.cs_n <= 1'b1;
            p_q.rd_n <= 1'b1;
            p_q.we_n <= '1;
            p_q.rdwr <= 1'b1;
        end else begin
            p_q <= p_d;
        end
    end

    assign bus_addr     = p_q.addr;
    assign bus_cs_n     = p_q.cs_n;
    assign bus_rd_n     = p_q.rd_n;
    assign bus_we_n     = p_q.we_n;
    assign bus_rdwr     = p_q.rdwr;
    assign bus_wdata    = p_q.wdata;
    assign bus_wdata_oe = p_q.oe;
    assign rd_data      = p_q.rdata;

endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
    import sram_strobe_pkg::*;
#(
    parameter  int ADDR_W = 24,
    parameter  int DATA_W = 32,
    localparam int LANES  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LANES-1:0]  req_be,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ack,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_cs_n,
    output logic              bus_rd_n,
    output logic [LANES-1:0]  bus_we_n,
    output logic              bus_rdwr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_wdata_oe,
    input  logic [DATA_W-1:0] bus_rdata
);

    timing_t cfg_now;
    phase_e  phase_next;
    logic    lane_mode_next;
    logic    accept;
    logic    capture;

    sram_timing_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_data (cfg_wdata),
        .timing  (cfg_now),
        .rd_data (cfg_rdata)
    );

    sram_phase_seq u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .cfg            (cfg_now),
        .phase_next     (phase_next),
        .lane_mode_next (lane_mode_next),
        .accept         (accept),
        .capture        (capture),
        .ack            (ack)
    );

    sram_strobe_gen #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_pins (
        .clk            (clk),
        .rst_n          (rst_n),
        .accept         (accept),
        .phase_next     (phase_next),
        .lane_mode_next (lane_mode_next),
        .capture        (capture),
        .req_write      (req_write),
        .req_addr       (req_addr),
        .req_be         (req_be),
        .req_wdata      (req_wdata),
        .bus_rdata      (bus_rdata),
        .bus_addr       (bus_addr),
        .bus_cs_n       (bus_cs_n),
        .bus_rd_n       (bus_rd_n),
        .bus_we_n       (bus_we_n),
        .bus_rdwr       (bus_rdwr),
        .bus_wdata      (bus_wdata),
        .bus_wdata_oe   (bus_wdata_oe),
        .rd_data        (rd_data)
    );

endmodule

// File: rtl/sram_strobe_checks.sv
module sram_strobe_checks #(
    parameter  int ADDR_W = 24,
    parameter  int DATA_W = 32,
    localparam int LANES  = DATA_W / 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ack,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_cs_n,
    input logic              bus_rd_n,
    input logic [LANES-1:0]  bus_we_n,
    input logic              bus_rdwr,
    input logic              bus_wdata_oe
);

    // R1: no strobe or drive while chip select is released
    a_r1_idle_pins: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cs_n |-> (bus_rd_n && (&bus_we_n) && bus_rdwr && !bus_wdata_oe));

    // R3: chip select falls at least one half cycle before the read strobe
    a_r3_setup_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_cs_n) |-> bus_rd_n);

    // R5: read strobe already negated in the cycle before chip select rises
    a_r5_hold_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_cs_n) |-> $past(bus_rd_n));

    // R8: read strobe never overlaps a write
    a_r8_rd_not_write: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_n |-> !bus_wdata_oe);

    // R9: acknowledge is a single cycle
    a_r9_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    // R9: acknowledge coincides with chip-select release
    a_r9_ack_at_release: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> $rose(bus_cs_n));

    // R10: chip select stays released for at least two cycles
    a_r10_cs_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_cs_n) |=> bus_cs_n);

    // R12: address steady while chip select is held
    a_r12_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_cs_n && $past(!bus_cs_n)) |-> $stable(bus_addr));

endmodule

bind sram_strobe_ctrl sram_strobe_checks #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_checks (
    .clk          (clk),
    .rst_n        (rst_n),
    .ack          (ack),
    .bus_addr     (bus_addr),
    .bus_cs_n     (bus_cs_n),
    .bus_rd_n     (bus_rd_n),
    .bus_we_n     (bus_we_n),
    .bus_rdwr     (bus_rdwr),
    .bus_wdata_oe (bus_wdata_oe)
);

// File: tb/test_sram_strobe_ctrl.sv
module test_sram_strobe_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 24;
    localparam int DW = 32;
    localparam int NB = DW / 8;
    localparam logic [31:0] CFG_MASK = 32'h0010_183F;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [31:0]   cfg_wdata = '0;
    logic [31:0]   cfg_rdata;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [NB-1:0] req_be = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          ack;
    logic [DW-1:0] rd_data;
    logic [AW-1:0] bus_addr;
    logic          bus_cs_n;
    logic          bus_rd_n;
    logic [NB-1:0] bus_we_n;
    logic          bus_rdwr;
    logic [DW-1:0] bus_wdata;
    logic          bus_wdata_oe;
    logic [DW-1:0] bus_rdata = '0;

    int vectors = 0;
    int fails = 0;
    bit run_chk = 0;
    int cyc = 0;

    sram_strobe_ctrl #(.ADDR_W(AW), .DATA_W(DW)) i_sram_strobe_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata), .ack(ack),
        .rd_data(rd_data), .bus_addr(bus_addr), .bus_cs_n(bus_cs_n),
        .bus_rd_n(bus_rd_n), .bus_we_n(bus_we_n), .bus_rdwr(bus_rdwr),
        .bus_wdata(bus_wdata), .bus_wdata_oe(bus_wdata_oe), .bus_rdata(bus_rdata)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Behavioural reference: t counts cycles since the accepting edge.
    bit            m_busy = 0, m_ack = 0, m_old_ack = 0, m_mode = 0, m_wr = 0;
    int            t = 0, S = 0, W = 0, H = 0, wcode = 0;
    logic [31:0]   m_cfg = '0;
    logic [AW-1:0] m_addr = '0;
    logic [NB-1:0] m_be = '0;
    logic [DW-1:0] m_wdata = '0, m_rdata = '0;

    always @(posedge clk) begin
        if (rst_n) begin
            m_old_ack = m_ack;
            m_ack = 0;
            if (m_busy) begin
                t = t + 1;
                if (t == S + W && !m_wr) m_rdata = bus_rdata;
                if (t == S + W + H) begin
                    m_busy = 0;
                    m_ack = 1;
                end
            end else if (!m_old_ack && req_valid) begin
                m_busy = 1;
                t = 0;
                wcode = int'(m_cfg[5:2]);
                S = 2 * int'(m_cfg[12:11]) + 1;
                W = 2 * ((wcode == 0) ? 1 : wcode);
                H = 2 * int'(m_cfg[1:0]) + 1;
                m_mode = m_cfg[20];
                m_wr = req_write;
                m_addr = req_addr;
                m_be = req_be;
                m_wdata = req_wdata;
            end
            if (cfg_we) m_cfg = cfg_wdata & CFG_MASK;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at cycle %0d: actual=%h expected=%h", tag, cyc, act, exp);
        end
    endtask

    // Compare every output against the model away from the rising edge.
    always @(negedge clk) begin
        cyc++;
        bus_rdata <= 32'h9E37_79B9 * (cyc + 1);
        if (run_chk) begin
            automatic bit strobe = m_busy && (t >= S) && (t < S + W);
            automatic logic [NB-1:0] exp_we;
            automatic logic exp_rdwr;
            for (int i = 0; i < NB; i++) begin
                if (m_mode) exp_we[i] = !(m_busy && m_be[i]);
                else        exp_we[i] = !(strobe && m_be[i]);
            end
            exp_rdwr = m_mode ? !(strobe && m_wr) : !(m_busy && m_wr);
            chk("R3 R5 chip select", 64'(bus_cs_n), 64'(!m_busy));
            chk("R4 R8 read strobe", 64'(bus_rd_n), 64'(!(strobe && !m_wr)));
            chk(m_mode ? "R7 lane enables" : "R6 lane enables", 64'(bus_we_n), 64'(exp_we));
            chk(m_mode ? "R7 direction" : "R6 direction", 64'(bus_rdwr), 64'(exp_rdwr));
            chk("R9 ack", 64'(ack), 64'(m_ack));
            chk("R9 read data", 64'(rd_data), 64'(m_rdata));
            chk("R12 data drive", 64'(bus_wdata_oe), 64'(m_busy && m_wr));
            chk("R2 cfg readback", 64'(cfg_rdata), 64'(m_cfg));
            if (m_busy) chk("R12 address", 64'(bus_addr), 64'(m_addr));
            if (m_busy && m_wr) chk("R12 write data", 64'(bus_wdata), 64'(m_wdata));
        end
    end

    task automatic cfg_write(input logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_access(input bit wr, input logic [AW-1:0] a, input logic [NB-1:0] be,
                             input logic [DW-1:0] d, input int exp_span, input string tag);
        int span;
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr = a;
        req_be = be;
        req_wdata = d;
        span = 0;
        do begin
            @(negedge clk);
            if (!bus_cs_n) span++;
        end while (!ack);
        req_valid = 1'b0;
        chk(tag, 64'(span), 64'(exp_span));
    endtask

    function automatic logic [31:0] mk_cfg(input int su, input int wd, input int hd, input bit md);
        return (32'(su) << 11) | (32'(wd) << 2) | 32'(hd) | (32'(md) << 20);
    endfunction

    initial begin
        int gap;
        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1 reset cs", 64'(bus_cs_n), 64'd1);
        chk("R1 reset rd", 64'(bus_rd_n), 64'd1);
        chk("R1 reset lanes", 64'(bus_we_n), 64'hF);
        chk("R1 reset dir", 64'(bus_rdwr), 64'd1);
        chk("R1 reset ack", 64'(ack), 64'd0);
        chk("R1 reset oe", 64'(bus_wdata_oe), 64'd0);
        chk("R1 reset cfg", 64'(cfg_rdata), 64'd0);
        rst_n = 1'b1;
        run_chk = 1;

        do_access(1, 24'h00_0123, 4'b1111, 32'hDEAD_BEEF, 4, "R3 R4 R5 default span write");
        do_access(0, 24'h00_0456, 4'b1111, 32'h0, 4, "R3 R4 R5 default span read");

        cfg_write(32'hFFFF_FFFF);
        chk("R2 reserved bits ignored", 64'(cfg_rdata), 64'h0010_183F);
        cfg_write(32'h0);
        chk("R2 clear", 64'(cfg_rdata), 64'h0);

        cfg_write(mk_cfg(2, 3, 1, 0));
        do_access(1, 24'h12_3400, 4'b0101, 32'h1122_3344, 14, "R6 mode0 write span");
        do_access(0, 24'h12_3404, 4'b0011, 32'h0, 14, "R6 mode0 read span");

        cfg_write(mk_cfg(1, 2, 2, 1));
        do_access(1, 24'h45_0000, 4'b1010, 32'hCAFE_F00D, 3 + 4 + 5, "R7 mode1 write span");
        do_access(0, 24'h45_0010, 4'b1100, 32'h0, 3 + 4 + 5, "R7 mode1 read span");

        cfg_write(mk_cfg(0, 0, 3, 0));
        do_access(0, 24'h00_0ABC, 4'b1000, 32'h0, 1 + 2 + 7, "R4 width code 0 acts as 1");
        cfg_write(mk_cfg(3, 15, 0, 1));
        do_access(1, 24'hFF_FFFC, 4'b0001, 32'h0102_0304, 7 + 30 + 1, "R3 R4 longest setup and width");

        // R11: configuration change during an access
        cfg_write(mk_cfg(1, 2, 1, 0));
        fork
            do_access(0, 24'h33_3330, 4'b1111, 32'h0, 3 + 4 + 3, "R11 access keeps latched timing");
            begin
                repeat (3) @(negedge clk);
                cfg_write(mk_cfg(3, 9, 3, 1));
            end
        join
        do_access(1, 24'h33_3334, 4'b0110, 32'h5555_AAAA, 7 + 18 + 7, "R11 next access uses new timing");

        // R10: request held high across two accesses
        cfg_write(mk_cfg(0, 1, 0, 0));
        @(negedge clk);
        req_valid = 1'b1;
        req_write = 1'b0;
        req_addr = 24'h77_0000;
        req_be = 4'b1111;
        do @(negedge clk); while (!ack);
        gap = 0;
        while (bus_cs_n && gap < 10) begin
            gap++;
            @(negedge clk);
        end
        chk("R10 chip-select gap with request held", 64'(gap), 64'd2);
        do @(negedge clk); while (!ack);
        req_valid = 1'b0;
        repeat (4) @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL R9 watchdog: actual=no completion expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule